// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers up to 32 hardware event sources into a sticky pending bitmask and raises one interrupt line while any enabled event is waiting. Most sources arrive as single-cycle pulses on `evt_in`. Five bit positions are produced inside the block:

- Three button qualifiers turn raw button levels into press, long-hold and release events. They count pulses of a periodic `tick` input.
- A battery comparator flags downward crossings of fixed charge thresholds.

A host reaches the block through a small byte-wide register port. Addresses 0 to 3 return the pending bitmask one byte at a time, and each read clears the bits it returned. Addresses 4 to 7 hold the 32-bit enable mask, where a 0 bit lets the matching event reach the interrupt. A typical handler reads the pending bytes after the interrupt rises. The read itself acknowledges the events.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, all pending bits are 0, every mask bit is 1 (all events disabled), `irq` is 0 and `reg_rdata` is 0.
- R2: A write to address 4+n (n = 0..3) loads mask bits [8n+7:8n]. A read of that address returns them without changing any state. A mask bit of 0 enables its event and 1 disables it.
- R3: `irq` is a register. It is 1 in the cycle after one in which (pending AND NOT mask) is non-zero, and 0 otherwise.
- R4: A 1 on `evt_in[k]` for one cycle sets pending bit k at that clock edge. This holds for every k except the internal positions 0, 1, 2, 3 and 13. A pulse on `evt_in` at one of those five positions has no effect.
- R5: A read of address n (n = 0..3) returns pending bits [8n+7:8n] on `reg_rdata` after that edge and clears exactly those bits. An event arriving in the same cycle as the read stays set. A write to addresses 0..3 changes nothing. Pending bits are never lost without a read.
- R6: With `pwr_btn` held, pending bit 0 (power press) is set after the 27th `tick` of the hold.
- R7: With `pwr_btn` held, pending bit 1 (power long hold) is set after the 375th `tick` of the hold.
- R8: With `home_btn` held, pending bit 2 (home press) is set after the 5th `tick`. Pending bit 3 (home release) is set when `home_btn` drops after a qualified press, and only then.
- R9: Each button event fires once per hold. Its counter restarts from zero when the button is released, including a release before the threshold is reached.
- R10: Pending bit 13 is set when `batt_chg` is 0 and `batt_pct` moves from above T to at or below T, for any T in {10, 5, 0}. One move that crosses several thresholds gives one event. No event is raised while charging or on rising levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Periodic qualification tick, one cycle wide |
| pwr_btn | input | 1 | Raw power button level, 1 = held |
| home_btn | input | 1 | Raw home button level, 1 = held |
| batt_pct | input | 7 | Battery charge level in percent |
| batt_chg | input | 1 | 1 while charging |
| evt_in | input | 32 | External single-cycle event pulses |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host byte address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid the cycle after a read |
| irq | output | 1 | Interrupt, high while an enabled event is pending |

## Verification
Each path has a fixed latency:

- An `evt_in` pulse is in the pending register one edge after it is sampled, and reaches `irq` one edge after that.
- Button and battery events pass through one extra register, so they reach pending two edges after the qualifying tick or level change.
- `reg_rdata` carries the addressed byte one edge after the read strobe.

The bench drives every input on the falling edge and samples on the falling edge after the due edge has passed. It checks `irq` exactly two edges after an external pulse, and it reads pending bytes only after an internal event has had two edges to settle. Tick-count thresholds are checked one tick short of the limit and at the limit.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int unsigned EVW     = 32;
  localparam int unsigned BYTES   = EVW / 8;
  localparam int unsigned SEL_W   = $clog2(BYTES);
  localparam int unsigned ADDR_W  = SEL_W + 1;
  localparam int unsigned PCT_W   = 7;

  localparam int unsigned POS_PWR_PRESS  = 0;
  localparam int unsigned POS_PWR_HOLD   = 1;
  localparam int unsigned POS_HOME_PRESS = 2;
  localparam int unsigned POS_HOME_REL   = 3;
  localparam int unsigned POS_BATT       = 13;

  localparam logic [EVW-1:0] INTERNAL_POS =
    (EVW'(1) << POS_PWR_PRESS) | (EVW'(1) << POS_PWR_HOLD) |
    (EVW'(1) << POS_HOME_PRESS) | (EVW'(1) << POS_HOME_REL) |
    (EVW'(1) << POS_BATT);

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
  } host_req_t;
endpackage

// File: rtl/btn_qual.sv
module btn_qual #(
  parameter int unsigned THRESH = 27,
  parameter bit          REL_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn,
  output logic press_o,
  output logic rel_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fired_q, fired_d;
  logic          press_q, press_d;
  logic          rel_d;

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    press_d = 1'b0;
    rel_d   = 1'b0;
    if (!btn) begin
      cnt_d   = '0;
      fired_d = 1'b0;
      rel_d   = fired_q;
    end else if (tick && !fired_q) begin
      if (cnt_q == CW'(THRESH - 1)) begin
        cnt_d   = '0;
        fired_d = 1'b1;
        press_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      press_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      press_q <= press_d;
    end
  end

  assign press_o = press_q;

  generate
    if (REL_EN) begin : g_rel
      logic rel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= rel_d;
      end
      assign rel_o = rel_q;
    end else begin : g_norel
      logic unused_rel;
      assign unused_rel = rel_d;
      assign rel_o      = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/batt_cross.sv
module batt_cross #(
  parameter int unsigned         LW  = 7,
  parameter int unsigned         NT  = 3,
  parameter logic [LW*NT-1:0]    THR = {7'd0, 7'd5, 7'd10}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic          charging,
  output logic          ev_o
);
  logic [LW-1:0] prev_q;
  logic          ev_q, ev_d;
  logic [NT-1:0] hit;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      assign hit[t] = (prev_q > THR[t*LW +: LW]) && (level <= THR[t*LW +: LW]);
    end
  endgenerate

  always_comb ev_d = !charging && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ev_q   <= 1'b0;
    end else begin
      prev_q <= level;
      ev_q   <= ev_d;
    end
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/pend_ctl.sv
module pend_ctl
  import evt_agg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] set_i,
  input  host_req_t      req_i,
  output logic [7:0]     rdata_o,
  output logic           irq_o,
  output logic [EVW-1:0] pend_o,
  output logic [EVW-1:0] mask_o
);
  logic [EVW-1:0] pend_q, pend_d, clr;
  logic [EVW-1:0] mask_q;
  logic [7:0]     rdata_q, rdata_d;
  logic           irq_q, irq_d;
  logic [SEL_W-1:0] sel;
  logic           rd_en;

  assign sel   = req_i.addr[SEL_W-1:0];
  assign rd_en = req_i.rd;

  always_comb begin
    clr = '0;
    if (req_i.rd && !req_i.addr[SEL_W])
      clr = pend_q & (EVW'(8'hFF) << {sel, 3'b000});
    pend_d  = (pend_q & ~clr) | set_i;
    rdata_d = req_i.addr[SEL_W] ? mask_q[{sel, 3'b000} +: 8]
                                : pend_q[{sel, 3'b000} +: 8];
    irq_d   = |(pend_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_mask
      logic en;
      assign en = req_i.wr && req_i.addr[SEL_W] && (sel == SEL_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask_q[b*8 +: 8] <= 8'hFF;
        else if (en) mask_q[b*8 +: 8] <= req_i.wdata;
      end
    end
  endgenerate

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_agg_pkg::*;
#(
  parameter int unsigned PWR_PRESS_TICKS  = 27,
  parameter int unsigned PWR_HOLD_TICKS   = 375,
  parameter int unsigned HOME_PRESS_TICKS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_btn,
  input  logic              home_btn,
  input  logic [PCT_W-1:0]  batt_pct,
  input  logic              batt_chg,
  input  logic [EVW-1:0]    evt_in,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic pwr_press_w, pwr_hold_w, home_press_w, home_rel_w, batt_ev_w;
  logic unused_rel0, unused_rel1;
  logic [EVW-1:0] int_set, set_w, pend_w, mask_w;
  host_req_t req;

  btn_qual #(.THRESH(PWR_PRESS_TICKS), .REL_EN(1'b0)) u_pwr_press (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn(pwr_btn),
    .press_o(pwr_press_w), .rel_o(unused_rel0));

  btn_qual #(.THRESH(PWR_HOLD_TICKS), .REL_EN(1'b0)) u_pwr_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn(pwr_btn),
    .press_o(pwr_hold_w), .rel_o(unused_rel1));

  btn_qual #(.THRESH(HOME_PRESS_TICKS), .REL_EN(1'b1)) u_home (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn(home_btn),
    .press_o(home_press_w), .rel_o(home_rel_w));

  batt_cross #(.LW(PCT_W)) u_batt (
    .clk(clk), .rst_n(rst_n), .level(batt_pct), .charging(batt_chg),
    .ev_o(batt_ev_w));

  always_comb begin
    int_set                 = '0;
    int_set[POS_PWR_PRESS]  = pwr_press_w;
    int_set[POS_PWR_HOLD]   = pwr_hold_w;
    int_set[POS_HOME_PRESS] = home_press_w;
    int_set[POS_HOME_REL]   = home_rel_w;
    int_set[POS_BATT]       = batt_ev_w;
    set_w = (evt_in & ~INTERNAL_POS) | int_set;
    req.rd    = reg_rd;
    req.wr    = reg_wr;
    req.addr  = reg_addr;
    req.wdata = reg_wdata;
  end

  pend_ctl u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .req_i(req),
    .rdata_o(reg_rdata), .irq_o(irq), .pend_o(pend_w), .mask_o(mask_w));
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
  import evt_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [EVW-1:0]    evt_in,
  input logic              pwr_btn,
  input logic              pwr_press,
  input logic [EVW-1:0]    pend,
  input logic [EVW-1:0]    mask,
  input logic [EVW-1:0]    set_vec,
  input logic              irq
);
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~mask)) |=> irq); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & ~mask)) |=> !irq); // R3
  AST_EXT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & ~INTERNAL_POS)) |=>
      ((pend & $past(evt_in & ~INTERNAL_POS)) == $past(evt_in & ~INTERNAL_POS))); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R5
  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (($past(pend) & ~pend) == '0)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[SEL_W]) |=>
      (mask[{$past(reg_addr[SEL_W-1:0]), 3'b000} +: 8] == $past(reg_wdata))); // R2
  AST_PRESS_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_btn |=> !pwr_press); // R9
endmodule

bind evt_irq_agg evt_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_in(evt_in),
  .pwr_btn(pwr_btn), .pwr_press(pwr_press_w), .pend(pend_w),
  .mask(mask_w), .set_vec(set_w), .irq(irq));

// File: tb/evt_irq_agg_bench.sv
module evt_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INTL = 32'h0000_200F;

  logic clk = 1'b0;
  logic rst_n, tick, pwr_btn, home_btn, batt_chg, reg_rd, reg_wr, irq;
  logic [6:0]  batt_pct;
  logic [31:0] evt_in;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_agg u_evt_irq_agg (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_btn(pwr_btn),
    .home_btn(home_btn), .batt_pct(batt_pct), .batt_chg(batt_chg),
    .evt_in(evt_in), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    step();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_pend(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step();
      tick = 1'b0; step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v, e;
    int prev;
    rst_n = 1'b0; tick = 1'b0; pwr_btn = 1'b0; home_btn = 1'b0;
    batt_pct = '0; batt_chg = 1'b0; evt_in = '0; reg_rd = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(); step();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", {24'b0, reg_rdata}, 32'h0);
    rst_n = 1'b1; step();
    for (int i = 4; i < 8; i++) begin
      rd(3'(i), b);
      chk("R1 mask", {24'b0, b}, 32'hFF);
    end
    rd_pend(v);
    chk("R1 pending", v, 32'h0);

    // R2: enable all, read back
    for (int i = 4; i < 8; i++) wr(3'(i), 8'h00);
    for (int i = 4; i < 8; i++) begin
      rd(3'(i), b);
      chk("R2 mask readback", {24'b0, b}, 32'h0);
    end

    // R3/R4/R5 sweep of every evt_in position, all enabled
    for (int k = 0; k < 32; k++) begin
      e = INTL[k] ? 32'h0 : (32'h1 << k);
      evt_in = 32'h1 << k; step();
      evt_in = '0; step();
      chk("R3 irq after pulse", {31'b0, irq}, {31'b0, |e});
      rd_pend(v);
      chk("R4 pending pattern", v, e);
      step();
      chk("R5 irq after clear", {31'b0, irq}, 32'h0);
    end

    // R2/R3 masked sweep over external positions
    for (int k = 0; k < 32; k++) begin
      if (!INTL[k]) begin
        wr(3'(4 + k/8), 8'hFF);
        evt_in = 32'h1 << k; step();
        evt_in = '0; step(); step();
        chk("R2 masked no irq", {31'b0, irq}, 32'h0);
        wr(3'(4 + k/8), ~(8'h1 << (k%8)));
        step();
        chk("R3 unmask raises irq", {31'b0, irq}, 32'h1);
        rd_pend(v);
        chk("R2 masked event still pending", v, 32'h1 << k);
        wr(3'(4 + k/8), 8'h00);
      end
    end

    // R5 same-cycle event survives read; write to pending ignored
    evt_in = 32'h20; step(); evt_in = '0;
    evt_in = 32'h40; reg_rd = 1'b1; reg_addr = 3'd0; step();
    evt_in = '0; reg_rd = 1'b0;
    chk("R5 read returns byte", {24'b0, reg_rdata}, 32'h20);
    rd(3'd0, b);
    chk("R5 same-cycle event kept", {24'b0, b}, 32'h40);
    evt_in = 32'h200; step(); evt_in = '0;
    wr(3'd1, 8'hFF); wr(3'd1, 8'h00);
    rd(3'd1, b);
    chk("R5 pending write ignored", {24'b0, b}, 32'h02);

    // R6/R7/R9 power button
    pwr_btn = 1'b1; step();
    ticks(26); rd(3'd0, b);
    chk("R6 no press before 27", {24'b0, b}, 32'h0);
    ticks(1); step(); rd(3'd0, b);
    chk("R6 press at 27", {24'b0, b}, 32'h1);
    ticks(347); rd(3'd0, b);
    chk("R9/R7 nothing before 375", {24'b0, b}, 32'h0);
    ticks(1); step(); rd(3'd0, b);
    chk("R7 hold at 375", {24'b0, b}, 32'h2);
    ticks(5); rd(3'd0, b);
    chk("R9 once per hold", {24'b0, b}, 32'h0);
    pwr_btn = 1'b0; step(); step(); step();
    rd(3'd0, b);
    chk("R8 no power release event", {24'b0, b}, 32'h0);
    pwr_btn = 1'b1; step();
    ticks(27); step(); rd(3'd0, b);
    chk("R9 re-armed after release", {24'b0, b}, 32'h1);
    pwr_btn = 1'b0; step();

    // R8/R9 home button
    home_btn = 1'b1; step();
    ticks(3);
    home_btn = 1'b0; step(); step(); step();
    rd(3'd0, b);
    chk("R8 no release before press", {24'b0, b}, 32'h0);
    home_btn = 1'b1; step();
    ticks(4); rd(3'd0, b);
    chk("R9 count restarted", {24'b0, b}, 32'h0);
    ticks(1); step(); rd(3'd0, b);
    chk("R8 home press at 5", {24'b0, b}, 32'h4);
    ticks(10); rd(3'd0, b);
    chk("R9 home once", {24'b0, b}, 32'h0);
    home_btn = 1'b0; step(); step(); step();
    rd(3'd0, b);
    chk("R8 home release", {24'b0, b}, 32'h8);

    // R10 battery crossings, bit 13 = byte1 bit5
    batt_chg = 1'b0; batt_pct = 7'd50; step(); step(); step();
    rd(3'd1, b);
    chk("R10 rising none", {24'b0, b}, 32'h0);
    prev = 50;
    for (int l = 49; l >= 0; l--) begin
      batt_pct = 7'(l); step(); step(); step();
      rd(3'd1, b);
      e = ((prev > 10 && l <= 10) || (prev > 5 && l <= 5) || (prev > 0 && l <= 0))
          ? 32'h20 : 32'h0;
      chk("R10 discharge sweep", {24'b0, b}, e);
      prev = l;
    end
    batt_chg = 1'b1; batt_pct = 7'd20; step(); step();
    batt_pct = 7'd3; step(); step(); step();
    rd(3'd1, b);
    chk("R10 none while charging", {24'b0, b}, 32'h0);
    batt_chg = 1'b0; batt_pct = 7'd12; step(); step();
    batt_pct = 7'd3; step(); step(); step();
    rd(3'd1, b);
    chk("R10 multi-threshold single event", {24'b0, b}, 32'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule